// File: doc/BRIEF.md
# USB Device Interrupt Status Unit

This block collects interrupt events for a USB device controller with a parameterised number of endpoints (five by default). It holds a summary register, a general event register, and one event register per endpoint. Each of these has a matching enable register. Every endpoint also has a response-control register that the endpoint logic reads as a plain output. Event pulses from the protocol and endpoint logic latch into sticky status bits whatever the enables hold. Software can therefore poll the status, or take the single interrupt line that combines every enabled status bit.

Software reaches the registers through a simple synchronous bus: an address, a write strobe and write data. Read data comes back registered, one cycle after the address is presented. The endpoint event bits are cleared by writing 1s. The summary register reports an endpoint as pending when any of its enabled event bits is set; software cannot write these pending bits. The start-of-frame flag sits in the top bit of the summary register and is cleared by writing 1 to it. Response bits have two addresses: writing 1s to one sets them, and writing 1s to the other clears them.

Top module: `usb_irq_unit`

## Requirements
- R1: After a synchronous reset, every status, enable and response bit reads 0, `ep_rsp` is 0 and `irq` is 0.
- R2: Summary bit n (n < NUM_EP) reads 1 exactly when endpoint n has a status bit whose enable bit is also set. Writes to the summary address never change bits NUM_EP-1..0. Bits between NUM_EP and DW-2 read 0.
- R3: A `sof_pulse` sets summary bit DW-1 (bit 7). Writing 1 to that bit at address 0x00 clears it. Writing 0 to it leaves it unchanged.
- R4: An event pulse sets its status bit even when the matching enable bit is 0.
- R5: `irq` is 1 exactly one cycle after some status bit and its enable bit are both 1. It stays 0 while no enabled status bit is set.
- R6: In the general event register (address 0x02) and in each endpoint event register (address 0x10+4n), writing 1 clears the matching bit and writing 0 leaves it unchanged.
- R7: When an event pulse and a write-1-to-clear hit the same bit in the same cycle, the bit ends up set.
- R8: Writing to an endpoint response set address (0x12+4n) sets the bits written as 1 and leaves the other bits unchanged.
- R9: Writing to an endpoint response clear address (0x13+4n) clears the bits written as 1. Both addresses read back the current value, which also drives `ep_rsp[n*DW +: DW]`.
- R10: The enable registers are plain read/write registers: summary enable at 0x01 (only bits NUM_EP-1..0 and bit DW-1 are kept), general enable at 0x03, and endpoint n enable at 0x11+4n.
- R11: `bus_rdata` presents, one cycle after the address, the register at `bus_addr`. An unmapped address reads as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | AW | Register address |
| bus_wr | input | 1 | Write strobe for this cycle |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Registered read data for the previous cycle's address |
| sof_pulse | input | 1 | One-cycle pulse when a start-of-frame token is received |
| gen_evt | input | DW | General event pulses, one per bit |
| ep_evt | input | NUM_EP*DW | Endpoint event pulses; endpoint n uses slice n*DW +: DW |
| ep_rsp | output | NUM_EP*DW | Response-control bits per endpoint |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions take the event inputs as single-cycle pulses sampled on the clock edge. They also assume that one cycle carries at most one bus write, so the set and clear addresses of a response register are never written together. The stimulus raises each event for exactly one cycle and changes the bus only at the falling edge. In the collision scenario it drives an event and a clearing write in the same cycle on purpose. Every read holds the address through one full cycle before sampling, which matches the registered read path.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
  localparam int unsigned SUM_ADDR    = 0;
  localparam int unsigned SUM_EN_ADDR = 1;
  localparam int unsigned GEN_ADDR    = 2;
  localparam int unsigned GEN_EN_ADDR = 3;
  localparam int unsigned EP_BASE     = 16;
  localparam int unsigned EP_STRIDE   = 4;

  typedef enum logic [1:0] {
    EPR_STAT = 2'd0,
    EPR_EN   = 2'd1,
    EPR_SET  = 2'd2,
    EPR_CLR  = 2'd3
  } ep_reg_e;

  function automatic int unsigned ep_reg_addr(int unsigned ep, ep_reg_e kind);
    return EP_BASE + ep * EP_STRIDE + int'(unsigned'(kind));
  endfunction
endpackage

// File: rtl/irq_w1c_bank.sv
module irq_w1c_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt,
  input  logic         clr_we,
  input  logic         en_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] stat,
  output logic [W-1:0] en,
  output logic         pend
);
  logic [W-1:0] clr_mask;

  assign clr_mask = clr_we ? wdata : '0;
  assign pend     = |(stat & en);

  always_ff @(posedge clk) begin
    if (rst) begin
      stat <= '0;
      en   <= '0;
    end else begin
      stat <= (stat & ~clr_mask) | evt;
      if (en_we) en <= wdata;
    end
  end

  AST_EVT_WINS: assert property (@(posedge clk) disable iff (rst)
    (|evt) |=> ((stat & $past(evt)) == $past(evt))); // R7
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (clr_we && ((wdata & ~evt) != '0)) |=> ((stat & $past(wdata) & ~$past(evt)) == '0)); // R6
  AST_SET_ONLY_BY_EVT: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((stat & ~$past(stat) & ~$past(evt)) == '0)); // R4
endmodule

// File: rtl/irq_rsp_bank.sv
module irq_rsp_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rsp
);
  always_ff @(posedge clk) begin
    if (rst)         rsp <= '0;
    else if (set_we) rsp <= rsp | wdata;
    else if (clr_we) rsp <= rsp & ~wdata;
  end

  AST_RSP_SET: assert property (@(posedge clk) disable iff (rst)
    set_we |=> ((rsp & $past(wdata)) == $past(wdata))); // R8
  AST_RSP_CLR: assert property (@(posedge clk) disable iff (rst)
    (clr_we && !set_we) |=> ((rsp & $past(wdata)) == '0)); // R9
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!set_we && !clr_we) |=> $stable(rsp)); // R9
endmodule

// File: rtl/usb_irq_unit.sv
module usb_irq_unit
  import usb_irq_pkg::*;
#(
  parameter int NUM_EP = 5,
  parameter int DW     = 8,
  parameter int AW     = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [AW-1:0]        bus_addr,
  input  logic                 bus_wr,
  input  logic [DW-1:0]        bus_wdata,
  output logic [DW-1:0]        bus_rdata,
  input  logic                 sof_pulse,
  input  logic [DW-1:0]        gen_evt,
  input  logic [NUM_EP*DW-1:0] ep_evt,
  output logic [NUM_EP*DW-1:0] ep_rsp,
  output logic                 irq
);
  localparam logic [DW-1:0] SUM_MASK =
    DW'((1 << NUM_EP) - 1) | (DW'(1) << (DW - 1));

  logic              hit_sum, hit_sum_en, hit_gen, hit_gen_en;
  logic              sof_q;
  logic [DW-1:0]     sum_en;
  logic [DW-1:0]     summary;
  logic [DW-1:0]     gen_stat, gen_en;
  logic              gen_pend;
  logic [NUM_EP-1:0] ep_pend;
  logic [DW-1:0]     ep_stat [NUM_EP];
  logic [DW-1:0]     ep_en   [NUM_EP];
  logic [DW-1:0]     rd_next;
  logic              irq_d;

  assign hit_sum    = bus_wr && (bus_addr == AW'(SUM_ADDR));
  assign hit_sum_en = bus_wr && (bus_addr == AW'(SUM_EN_ADDR));
  assign hit_gen    = bus_wr && (bus_addr == AW'(GEN_ADDR));
  assign hit_gen_en = bus_wr && (bus_addr == AW'(GEN_EN_ADDR));

  // General event register with its enable
  irq_w1c_bank #(.W(DW)) u_gen (
    .clk(clk), .rst(rst), .evt(gen_evt),
    .clr_we(hit_gen), .en_we(hit_gen_en), .wdata(bus_wdata),
    .stat(gen_stat), .en(gen_en), .pend(gen_pend)
  );

  // One event bank and one response bank per endpoint
  for (genvar n = 0; n < NUM_EP; n++) begin : g_ep
    logic hit_stat, hit_en, hit_set, hit_clr;
    assign hit_stat = bus_wr && (bus_addr == AW'(ep_reg_addr(n, EPR_STAT)));
    assign hit_en   = bus_wr && (bus_addr == AW'(ep_reg_addr(n, EPR_EN)));
    assign hit_set  = bus_wr && (bus_addr == AW'(ep_reg_addr(n, EPR_SET)));
    assign hit_clr  = bus_wr && (bus_addr == AW'(ep_reg_addr(n, EPR_CLR)));

    irq_w1c_bank #(.W(DW)) u_evt (
      .clk(clk), .rst(rst), .evt(ep_evt[n*DW +: DW]),
      .clr_we(hit_stat), .en_we(hit_en), .wdata(bus_wdata),
      .stat(ep_stat[n]), .en(ep_en[n]), .pend(ep_pend[n])
    );

    irq_rsp_bank #(.W(DW)) u_rsp (
      .clk(clk), .rst(rst), .set_we(hit_set), .clr_we(hit_clr),
      .wdata(bus_wdata), .rsp(ep_rsp[n*DW +: DW])
    );
  end

  // Start-of-frame flag and summary enable
  always_ff @(posedge clk) begin
    if (rst) begin
      sof_q  <= 1'b0;
      sum_en <= '0;
    end else begin
      sof_q <= (sof_q & ~(hit_sum & bus_wdata[DW-1])) | sof_pulse;
      if (hit_sum_en) sum_en <= bus_wdata & SUM_MASK;
    end
  end

  always_comb begin
    summary             = '0;
    summary[NUM_EP-1:0] = ep_pend;
    summary[DW-1]       = sof_q;
  end

  assign irq_d = (|(summary & sum_en)) | gen_pend;

  // Read mux
  always_comb begin
    rd_next = '0;
    if (bus_addr == AW'(SUM_ADDR))    rd_next = summary;
    if (bus_addr == AW'(SUM_EN_ADDR)) rd_next = sum_en;
    if (bus_addr == AW'(GEN_ADDR))    rd_next = gen_stat;
    if (bus_addr == AW'(GEN_EN_ADDR)) rd_next = gen_en;
    for (int n = 0; n < NUM_EP; n++) begin
      if (bus_addr == AW'(ep_reg_addr(n, EPR_STAT))) rd_next = ep_stat[n];
      if (bus_addr == AW'(ep_reg_addr(n, EPR_EN)))   rd_next = ep_en[n];
      if (bus_addr == AW'(ep_reg_addr(n, EPR_SET)) ||
          bus_addr == AW'(ep_reg_addr(n, EPR_CLR)))  rd_next = ep_rsp[n*DW +: DW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      bus_rdata <= rd_next;
      irq       <= irq_d;
    end
  end

  AST_SOF_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
    sof_pulse |=> summary[DW-1]); // R3
  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    irq |-> ($past(sum_en) != '0 || $past(gen_en) != '0)); // R5
  AST_IRQ_FOLLOWS_PEND: assert property (@(posedge clk) disable iff (rst)
    (gen_pend || (|(summary & sum_en))) |=> irq); // R5
  AST_SUM_EN_MASKED: assert property (@(posedge clk) disable iff (rst)
    (sum_en & ~SUM_MASK) == '0); // R10
endmodule

// File: tb/tb_usb_irq_unit.sv
module tb_usb_irq_unit;
  localparam int NUM_EP = 5;
  localparam int DW = 8;
  localparam int AW = 8;

  logic clk = 0, rst = 1;
  logic [AW-1:0] bus_addr = '0;
  logic bus_wr = 0;
  logic [DW-1:0] bus_wdata = '0, bus_rdata;
  logic sof_pulse = 0;
  logic [DW-1:0] gen_evt = '0;
  logic [NUM_EP*DW-1:0] ep_evt = '0, ep_rsp;
  logic irq;
  int n_chk = 0, n_fail = 0;

  usb_irq_unit #(.NUM_EP(NUM_EP), .DW(DW), .AW(AW)) dut (.*);

  always #4 clk = ~clk;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [DW-1:0] d);
    @(negedge clk); bus_addr = AW'(a); bus_wdata = d; bus_wr = 1;
    @(posedge clk); @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(int a, output logic [DW-1:0] d);
    @(negedge clk); bus_addr = AW'(a); bus_wr = 0;
    @(posedge clk); @(negedge clk); d = bus_rdata;
  endtask

  task automatic pulse(logic s, logic [DW-1:0] g, logic [NUM_EP*DW-1:0] e);
    @(negedge clk); sof_pulse = s; gen_evt = g; ep_evt = e;
    @(posedge clk); @(negedge clk); sof_pulse = 0; gen_evt = '0; ep_evt = '0;
  endtask

  task automatic t_reset();
    logic [DW-1:0] d;
    rd(0, d); chk("R1 summary", d, 0);
    rd(1, d); chk("R1 sum_en", d, 0);
    rd(2, d); chk("R1 gen stat", d, 0);
    rd(18, d); chk("R1 rsp", d, 0);
    chk("R1 ep_rsp", ep_rsp, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_sof();
    logic [DW-1:0] d;
    pulse(1, 0, 0);
    rd(0, d); chk("R3 sof set (R4 no enable)", d, 8'h80);
    chk("R5 irq off without enable", irq, 0);
    wr(0, 8'h1F);
    rd(0, d); chk("R2 R3 low write ignored", d, 8'h80);
    wr(0, 8'h80);
    rd(0, d); chk("R3 sof cleared", d, 0);
  endtask

  task automatic t_gen();
    logic [DW-1:0] d;
    pulse(0, 8'hA5, 0);
    rd(2, d); chk("R4 gen stat set", d, 8'hA5);
    wr(2, 8'h0F);
    rd(2, d); chk("R6 w1c", d, 8'hA0);
    wr(2, 8'h00);
    rd(2, d); chk("R6 write 0 no effect", d, 8'hA0);
    wr(3, 8'h20);
    chk("R5 irq latency", irq, 0);
    @(negedge clk); chk("R5 irq raised", irq, 1);
    rd(3, d); chk("R10 gen_en readback", d, 8'h20);
    wr(3, 8'h00);
    @(negedge clk); chk("R5 irq dropped", irq, 0);
  endtask

  task automatic t_ep();
    logic [DW-1:0] d;
    pulse(0, 0, 40'h04 << (3*DW));
    rd(28, d); chk("R4 ep3 stat", d, 8'h04);
    rd(0, d); chk("R2 no pend without enable", d, 0);
    wr(29, 8'h04);
    rd(29, d); chk("R10 ep3 en readback", d, 8'h04);
    rd(0, d); chk("R2 ep3 pending", d, 8'h08);
    chk("R5 irq off, summary not enabled", irq, 0);
    wr(1, 8'hFF);
    rd(1, d); chk("R10 sum_en masked", d, 8'h9F);
    chk("R5 irq on", irq, 1);
    wr(28, 8'h04);
    @(negedge clk);
    rd(0, d); chk("R2 pend cleared", d, 0);
    chk("R5 irq off after clear", irq, 0);
  endtask

  task automatic t_collide();
    logic [DW-1:0] d;
    @(negedge clk);
    ep_evt = 40'h01 << DW; bus_addr = 20; bus_wdata = 8'h03; bus_wr = 1;
    @(posedge clk); @(negedge clk); ep_evt = '0; bus_wr = 0;
    rd(20, d); chk("R7 event wins", d, 8'h01);
  endtask

  task automatic t_rsp();
    logic [DW-1:0] d;
    wr(26, 8'h0C);
    rd(26, d); chk("R8 set", d, 8'h0C);
    rd(27, d); chk("R9 clr addr readback", d, 8'h0C);
    wr(26, 8'h81);
    rd(26, d); chk("R8 set keeps others", d, 8'h8D);
    wr(27, 8'h04);
    rd(27, d); chk("R9 clear", d, 8'h89);
    chk("R9 ep_rsp output", ep_rsp, 40'h89 << (2*DW));
    rd(5, d); chk("R11 unmapped reads 0", d, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    t_reset(); t_sof(); t_gen(); t_ep(); t_collide(); t_rsp();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule